// File: doc/BRIEF.md
# Column Readout and Capture Sequencer

Once a row of the image array has been selected and sampled onto the column amplifiers, this block reads that row out one column at a time. It steps a column address across a window that software sets up as a first column, a last column and a stride. For every column it drives the address and raises the column load strobe. It then pulses the column clock that moves the decoded selection into the column register. It also pulses the converter clock and samples the converter's parallel word once that word has settled.

The analog path needs three column clock edges before a column's level reaches the converter input. A captured word therefore belongs to the address presented three slots earlier. A small shift register of column tags follows the address stream through that latency. Each word leaves the block tagged with its own column, and the final column carries an end-of-line flag. After the last address, the block keeps pulsing the clocks until the pipeline has drained. It then pulses `line_done` and releases the converter outputs to high impedance.

The gain code, the analog channel code and the converter polarity control are sampled when a line starts. They are held as static outputs for the whole line.

Top module: `col_readout_seq`

## Requirements
- R1: On a `line_start` pulse while idle, the addresses presented are the first column, then first + stride, then first + 2×stride, and so on, up to the largest such value not above the last column. A stride of 0 is treated as 1.
- R2: Exactly one column (the first) is read when the first column exceeds the last column, or when first + stride exceeds the last column. This also holds at the top address 1023.
- R3: Each column slot lasts 10 cycles. The address changes only at slot start. `col_load` rises 5 cycles (40 ns) after the address change, and the address then stays unchanged for at least 40 ns. `col_clk` rises one cycle after `col_load`.
- R4: `adc_clk` falls 8 cycles into each slot, after `col_clk` has risen. `adc_data` is sampled 24 ns after that falling edge, which covers the converter's 20 ns output delay.
- R5: Each `pix_valid` word carries `pix_col`, equal to the address presented three slots before its capture slot. `pix_data` is the converter word, unmodified.
- R6: Each column produces exactly one valid word, in address order. `pix_eol` is high only with the last column's word. `line_done` pulses in that same cycle, and `busy` then drops.
- R7: A `line_start` pulse while `busy` is high is ignored: the running line and its window are unaffected, and no extra line follows.
- R8: `adc_hiz` is 0 (converter outputs enabled) for the whole line and 1 when idle.
- R9: `gain_sel` (00 x1, 01 x2, 10 x4, 11 x8) and `chan_sel` (00 image, 01 to 11 auxiliary inputs 1 to 3) pass the codes sampled at `line_start` through unchanged. `adc_keep_pol` is the inverse of the sampled `cfg_black_high` (1 = no inversion, black reads 0; 0 = inverted, black reads 1023). All three stay static while `busy` is high.
- R10: After reset: `busy` 0, `pix_valid` 0, `line_done` 0, `col_load` 0, `col_clk` 0, `adc_clk` 1 and `adc_hiz` 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| line_start | input | 1 | Pulse to start reading the current row |
| win_first | input | AW | First column of the window |
| win_last | input | AW | Last column bound of the window |
| win_step | input | AW | Column stride (0 acts as 1) |
| cfg_gain | input | 2 | Gain code to present during the line |
| cfg_chan | input | 2 | Analog channel code to present during the line |
| cfg_black_high | input | 1 | 1 = black should read full scale |
| adc_data | input | DW | Converter parallel result |
| col_addr | output | AW | Column address to the array |
| col_load | output | 1 | Column address load strobe (latch on rise) |
| col_clk | output | 1 | Column register clock |
| adc_clk | output | 1 | Converter clock (converts on fall) |
| adc_hiz | output | 1 | 1 = converter outputs high impedance |
| adc_keep_pol | output | 1 | 1 = converter output not inverted |
| gain_sel | output | 2 | Static gain code |
| chan_sel | output | 2 | Static channel code |
| busy | output | 1 | Line readout in progress |
| pix_valid | output | 1 | Captured word valid |
| pix_data | output | DW | Captured converter word |
| pix_col | output | AW | Column the word belongs to |
| pix_eol | output | 1 | Word is the last of the line |
| line_done | output | 1 | One-cycle pulse at end of line |

## Verification
The bench models the sensor's three-edge column pipeline. It also models the converter: for 20 ns after each falling clock the converter drives the bitwise complement of the coming value, and only then the valid word. A sequencer that samples too early therefore returns wrong data, and one whose tag depth is off by a slot returns every pixel under a neighbouring column's index. The bench aims at windows whose end is not a stride multiple, a zero stride, a first column above the last, and a single column at address 1023. A design that let the sum wrap at 1024 there would run on through low addresses. Other checks fire setup and hold timers on every address change and load edge. A restart pulse and configuration changes are injected mid-line, which would expose a sequencer that re-samples its window or its select codes.

// File: rtl/col_readout_seq.sv
`timescale 1ns/1ps
module col_readout_seq #(
  parameter int AW      = 10,
  parameter int DW      = 10,
  parameter int SLOT    = 10,
  parameter int LD_AT   = 5,
  parameter int CK_AT   = 6,
  parameter int CONV_AT = 8,
  parameter int CAP_DLY = 3,
  parameter int LAT     = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          line_start,
  input  logic [AW-1:0] win_first,
  input  logic [AW-1:0] win_last,
  input  logic [AW-1:0] win_step,
  input  logic [1:0]    cfg_gain,
  input  logic [1:0]    cfg_chan,
  input  logic          cfg_black_high,
  input  logic [DW-1:0] adc_data,
  output logic [AW-1:0] col_addr,
  output logic          col_load,
  output logic          col_clk,
  output logic          adc_clk,
  output logic          adc_hiz,
  output logic          adc_keep_pol,
  output logic [1:0]    gain_sel,
  output logic [1:0]    chan_sel,
  output logic          busy,
  output logic          pix_valid,
  output logic [DW-1:0] pix_data,
  output logic [AW-1:0] pix_col,
  output logic          pix_eol,
  output logic          line_done
);
  localparam int PW     = $clog2(SLOT);
  localparam int CAP_AT = CONV_AT + CAP_DLY - 1 - SLOT;

  logic [PW-1:0] ph;
  logic          run;
  logic [AW-1:0] cur_col, step_r, last_r;
  logic          cur_vld, cur_last;
  logic [LAT-1:0] tag_v, tag_e;
  logic [AW-1:0] tag_c [LAT];
  logic [1:0]    gain_r, chan_r;
  logic          pol_r;

  wire slot_end = run && (ph == PW'(SLOT-1));
  wire cap      = run && (ph == PW'(CAP_AT)) && tag_v[LAT-1];

  wire [AW-1:0] step_in = (win_step == '0) ? AW'(1) : win_step;
  wire [AW+1:0] nxt     = {2'b00, cur_col} + {2'b00, step_r};
  wire [AW+1:0] nxt2    = nxt + {2'b00, step_r};
  wire start_last = ({2'b00, win_first} + {2'b00, step_in}) > {2'b00, win_last};
  wire adv_last   = nxt2 > {2'b00, last_r};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph <= '0; run <= 1'b0;
      cur_col <= '0; step_r <= AW'(1); last_r <= '0;
      cur_vld <= 1'b0; cur_last <= 1'b0;
      tag_v <= '0; tag_e <= '0;
      for (int i = 0; i < LAT; i++) tag_c[i] <= '0;
      gain_r <= '0; chan_r <= '0; pol_r <= 1'b0;
      pix_valid <= 1'b0; pix_data <= '0; pix_col <= '0;
      pix_eol <= 1'b0; line_done <= 1'b0;
    end else begin
      pix_valid <= 1'b0;
      pix_eol   <= 1'b0;
      line_done <= 1'b0;
      if (!run) begin
        ph <= '0;
        if (line_start) begin
          run      <= 1'b1;
          cur_col  <= win_first;
          cur_vld  <= 1'b1;
          cur_last <= start_last;
          step_r   <= step_in;
          last_r   <= win_last;
          tag_v    <= '0;
          gain_r   <= cfg_gain;
          chan_r   <= cfg_chan;
          pol_r    <= cfg_black_high;
        end
      end else begin
        ph <= slot_end ? '0 : ph + PW'(1);
        if (slot_end) begin
          tag_v <= {tag_v[LAT-2:0], cur_vld};
          tag_e <= {tag_e[LAT-2:0], cur_last};
          tag_c[0] <= cur_col;
          for (int i = 1; i < LAT; i++) tag_c[i] <= tag_c[i-1];
          if (cur_vld) begin
            if (cur_last) cur_vld <= 1'b0;
            else begin
              cur_col  <= nxt[AW-1:0];
              cur_last <= adv_last;
            end
          end
        end
        if (cap) begin
          pix_valid <= 1'b1;
          pix_data  <= adc_data;
          pix_col   <= tag_c[LAT-1];
          pix_eol   <= tag_e[LAT-1];
          if (tag_e[LAT-1]) begin
            run       <= 1'b0;
            line_done <= 1'b1;
          end
        end
      end
    end
  end

  assign col_addr     = cur_col;
  assign col_load     = run && (ph >= PW'(LD_AT));
  assign col_clk      = run && (ph >= PW'(CK_AT));
  assign adc_clk      = !(run && (ph >= PW'(CONV_AT)));
  assign adc_hiz      = !run;
  assign adc_keep_pol = !pol_r;
  assign gain_sel     = gain_r;
  assign chan_sel     = chan_r;
  assign busy         = run;

  a_r3_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (col_load && $past(col_load)) |-> $stable(col_addr));
  a_r3_clk_after_load: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(col_clk) |-> $past(col_load));
  a_r4_conv_after_clk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(adc_clk) |-> col_clk);
  a_r6_eol_done: assert property (@(posedge clk) disable iff (!rst_n)
    pix_eol |-> (pix_valid && line_done));
  a_r6_idle_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    line_done |-> !busy);
  a_r9_static_sel: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(gain_sel) && $stable(chan_sel) && $stable(adc_keep_pol)));
endmodule

// File: tb/tb_col_readout_seq.sv
`timescale 1ns/1ps
module tb_col_readout_seq;
  logic clk = 1'b0, rst_n = 1'b0, line_start = 1'b0;
  logic [9:0] win_first = '0, win_last = '0, win_step = '0;
  logic [1:0] cfg_gain = '0, cfg_chan = '0;
  logic cfg_black_high = 1'b0;
  logic [9:0] adc_data = '0;
  logic [9:0] col_addr, pix_data, pix_col;
  logic col_load, col_clk, adc_clk, adc_hiz, adc_keep_pol, busy, pix_valid, pix_eol, line_done;
  logic [1:0] gain_sel, chan_sel;

  col_readout_seq dut (.*);

  always #4 clk = ~clk;

  int errors = 0, checks = 0, cyc = 0;
  int exp_col [1024];
  int exp_n = 0, got_n = 0, done_seen = 0, hiz_err = 0, tim_err = 0;
  logic exp_blk = 1'b0;
  realtime t_addr = -1000.0, t_ld = -1000.0;
  int lat_a = 0, xr = 0, s2 = 0, ana = 0;

  function automatic int pixf(int c);
    return (c * 13 + 77) % 1024;
  endfunction

  task automatic chk(bit ok, string req, int act, int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  // sensor and converter model
  always @(col_addr) begin
    if ($realtime - t_ld < 40.0) tim_err++;
    t_addr = $realtime;
  end
  always @(posedge col_load) begin
    if ($realtime - t_addr < 40.0) tim_err++;
    t_ld = $realtime;
    lat_a = int'(col_addr);
  end
  always @(posedge col_clk) begin
    ana = s2; s2 = xr; xr = lat_a;
  end
  always @(negedge adc_clk) begin
    automatic int v = adc_keep_pol ? pixf(ana) : 1023 - pixf(ana);
    if (!col_clk) tim_err++;
    adc_data = ~10'(v);
    #20;
    adc_data = 10'(v);
  end

  // output monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (busy && adc_hiz) hiz_err++;
      if (pix_valid) begin
        if (got_n < exp_n) begin
          automatic int e = pixf(exp_col[got_n]);
          if (exp_blk) e = 1023 - e;
          chk(int'(pix_col) == exp_col[got_n], "R1/R5 column", int'(pix_col), exp_col[got_n]);
          chk(int'(pix_data) == e, "R4/R5 data", int'(pix_data), e);
          chk(pix_eol == (got_n == exp_n - 1), "R6 eol", int'(pix_eol), int'(got_n == exp_n - 1));
        end else chk(0, "R6 extra word", got_n + 1, exp_n);
        got_n++;
      end
      if (pix_eol) chk(line_done, "R6 done with eol", int'(line_done), 1);
      if (line_done) done_seen++;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      chk(0, "watchdog", cyc, 150000);
      summary();
      $finish;
    end
  end

  task automatic run_line(int f, int l, int s, logic [1:0] g, logic [1:0] ch, logic blk,
                          bit midcfg, bit restart);
    int st, c;
    st = (s == 0) ? 1 : s;
    exp_n = 0; c = f;
    exp_col[exp_n++] = f;
    while (c + st <= l) begin c += st; exp_col[exp_n++] = c; end
    got_n = 0; done_seen = 0; hiz_err = 0; tim_err = 0; exp_blk = blk;
    @(negedge clk);
    win_first = 10'(f); win_last = 10'(l); win_step = 10'(s);
    cfg_gain = g; cfg_chan = ch; cfg_black_high = blk;
    line_start = 1'b1;
    @(negedge clk);
    line_start = 1'b0;
    for (int k = 0; k < 12000 && done_seen == 0; k++) begin
      if (midcfg && k == 50) begin
        cfg_gain = ~g; cfg_chan = ~ch; cfg_black_high = ~blk;
      end
      if (midcfg && k == 52) begin
        chk(gain_sel == g, "R9 gain static", int'(gain_sel), int'(g));
        chk(chan_sel == ch, "R9 chan static", int'(chan_sel), int'(ch));
        chk(adc_keep_pol == !blk, "R9 polarity static", int'(adc_keep_pol), int'(!blk));
      end
      if (restart && k == 60) begin
        win_first = 10'd0; win_last = 10'd3; win_step = 10'd1; line_start = 1'b1;
      end
      if (restart && k == 61) line_start = 1'b0;
      @(negedge clk);
    end
    repeat (40) @(negedge clk);
    chk(got_n == exp_n, "R6 word count", got_n, exp_n);
    chk(done_seen == 1, "R6 single done", done_seen, 1);
    chk(!busy && adc_hiz, "R8 idle hiz", int'(adc_hiz), 1);
    chk(hiz_err == 0, "R8 enabled while busy", hiz_err, 0);
    chk(tim_err == 0, "R3/R4 strobe timing", tim_err, 0);
    chk(gain_sel == g && chan_sel == ch, "R9 codes", int'({gain_sel, chan_sel}), int'({g, ch}));
  endtask

  task automatic t_reset();
    chk(!busy && !pix_valid && !line_done, "R10 idle outputs", int'({busy, pix_valid, line_done}), 0);
    chk(!col_load && !col_clk && adc_clk && adc_hiz, "R10 strobes",
        int'({col_load, col_clk, adc_clk, adc_hiz}), 3);
  endtask
  task automatic t_basic();     run_line(0, 15, 1, 2'b00, 2'b00, 1'b0, 0, 0); endtask // R1 R5
  task automatic t_stride();    run_line(100, 200, 7, 2'b10, 2'b00, 1'b0, 0, 0); endtask // R1
  task automatic t_zero_step(); run_line(5, 8, 0, 2'b01, 2'b00, 1'b0, 0, 0); endtask // R1
  task automatic t_top_addr();  run_line(1023, 1023, 1, 2'b00, 2'b11, 1'b0, 0, 0); endtask // R2
  task automatic t_reversed();  run_line(300, 20, 4, 2'b00, 2'b10, 1'b0, 0, 0); endtask // R2
  task automatic t_cfg_static(); run_line(10, 40, 5, 2'b11, 2'b01, 1'b1, 1, 0); endtask // R9
  task automatic t_restart();   run_line(50, 90, 3, 2'b01, 2'b00, 1'b0, 0, 1); endtask // R7
  task automatic t_full();      run_line(0, 1023, 1, 2'b00, 2'b00, 1'b1, 0, 0); endtask // R6

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_stride();
    t_zero_step();
    t_top_addr();
    t_reversed();
    t_cfg_static();
    t_restart();
    t_full();
    summary();
    $finish;
  end
endmodule